// File: doc/BRIEF.md
# Data Value Match Comparator

This block watches the data word carried by each load or store and compares it against two programmable compare values. Each comparator picks which byte lanes of the word take part through its own lane-select mask. A two-bit rule field chooses what counts as a hit: every selected byte equal, any single selected byte equal, or any single fully selected halfword equal. The zero rule code is treated as switched off.

A hit raises that comparator's event flag for exactly one clock. The flag goes high on the clock edge after the cycle in which the access strobe was high. The two comparators share the data word and the strobe, and nothing else. Address qualification, the way value events combine with address events, and the programming of the compare values all sit outside this block. The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the event registers leave reset two clocks after the input rises.

Top module: `dvm_value_match`

## Requirements
- R1: The two comparators (suffixes a and b) are independent: each uses only its own compare value, lane mask and rule, and each can report an event while the other does not in the same cycle.
- R2: Byte lane i is bits 8*i+7:8*i of the data word and of the compare value, and is selected by mask bit i (lane 0 is bits 7:0). A lane whose mask bit is 0 has no effect on the result.
- R3: Rule code 2'b01 gives an event when every selected byte equals its compare byte.
- R4: Rule code 2'b10 gives an event when at least one selected byte equals its compare byte.
- R5: Rule code 2'b11 gives an event when, in at least one of the halfwords {lane 1, lane 0} or {lane 3, lane 2}, both lanes are selected and both bytes are equal. A match in lanes from two different halfwords does not count.
- R6: Rule code 2'b00 never gives an event.
- R7: A lane mask of 4'b0000 never gives an event, whatever the rule.
- R8: Events are evaluated only in cycles where the access strobe is high. The event flag is high in the cycle after the access and is low in the following cycle unless another matching access occurs.
- R9: While reset is asserted, and until the synchronised release, both event flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe; the data word is valid this cycle |
| acc_data | input | 32 | Data word of the load or store |
| cmp_val_a | input | 32 | Compare value, comparator a |
| lane_sel_a | input | 4 | Lane-select mask, comparator a |
| rule_a | input | 2 | Match rule, comparator a |
| cmp_val_b | input | 32 | Compare value, comparator b |
| lane_sel_b | input | 4 | Lane-select mask, comparator b |
| rule_b | input | 2 | Match rule, comparator b |
| evt_a | output | 1 | Registered event pulse, comparator a |
| evt_b | output | 1 | Registered event pulse, comparator b |

## Verification
The vector table sets full-word matches against single-lane mismatches to separate the all-bytes rule from the any-byte rule. It places equal bytes in lanes the mask leaves out to show that unselected lanes are ignored. One pattern has equal bytes in lanes 2 and 1 only; it separates a true halfword match from two matches that straddle halfwords. Pairs of vectors give comparator a and comparator b opposite outcomes on the same data word, which exposes any crossed wiring. Directed cases cover a dropped strobe, back-to-back accesses against the single-cycle pulse, and matching inputs held during reset.

// File: rtl/dvm_pkg.sv
package dvm_pkg;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned NUM_LANE = 4;
  localparam int unsigned WORD_W   = LANE_W * NUM_LANE;

  typedef enum logic [1:0] {
    RULE_OFF      = 2'b00,
    RULE_ALL      = 2'b01,
    RULE_ANY_BYTE = 2'b10,
    RULE_ANY_HALF = 2'b11
  } rule_e;
endpackage

// File: rtl/dvm_rst_sync.sv
module dvm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dvm_lane_cmp.sv
module dvm_lane_cmp #(
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned NUM_LANE = 4,
  localparam int unsigned WORD_W  = LANE_W * NUM_LANE
) (
  input  logic [WORD_W-1:0]   data_i,
  input  logic [WORD_W-1:0]   ref_i,
  output logic [NUM_LANE-1:0] eq_o
);
  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
    assign eq_o[g] = (data_i[g*LANE_W +: LANE_W] == ref_i[g*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/dvm_rule_eval.sv
module dvm_rule_eval
  import dvm_pkg::*;
#(
  parameter int unsigned NUM_LANE = 4,
  localparam int unsigned NUM_HALF = NUM_LANE / 2
) (
  input  logic [NUM_LANE-1:0] eq_i,
  input  logic [NUM_LANE-1:0] sel_i,
  input  logic [1:0]          rule_i,
  output logic                hit_o
);
  logic [NUM_LANE-1:0] sel_eq;
  logic [NUM_HALF-1:0] half_hit;
  logic                all_hit;
  logic                any_hit;
  logic                any_sel;

  assign sel_eq = eq_i & sel_i;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    assign half_hit[h] = &sel_i[2*h +: 2] && &eq_i[2*h +: 2];
  end

  assign any_sel = |sel_i;
  assign all_hit = any_sel && ((eq_i | ~sel_i) == {NUM_LANE{1'b1}});
  assign any_hit = |sel_eq;

  always_comb begin
    unique case (rule_e'(rule_i))
      RULE_ALL:      hit_o = all_hit;
      RULE_ANY_BYTE: hit_o = any_hit;
      RULE_ANY_HALF: hit_o = |half_hit;
      default:       hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dvm_channel.sv
module dvm_channel
  import dvm_pkg::*;
#(
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned NUM_LANE = 4,
  localparam int unsigned WORD_W  = LANE_W * NUM_LANE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic [WORD_W-1:0]   data_i,
  input  logic [WORD_W-1:0]   ref_i,
  input  logic [NUM_LANE-1:0] sel_i,
  input  logic [1:0]          rule_i,
  output logic                evt_o
);
  logic [NUM_LANE-1:0] lane_eq;
  logic                rule_hit;
  logic                evt_d;
  logic                evt_q;

  dvm_lane_cmp #(.LANE_W(LANE_W), .NUM_LANE(NUM_LANE)) u_cmp (
    .data_i (data_i),
    .ref_i  (ref_i),
    .eq_o   (lane_eq)
  );

  dvm_rule_eval #(.NUM_LANE(NUM_LANE)) u_rule (
    .eq_i   (lane_eq),
    .sel_i  (sel_i),
    .rule_i (rule_i),
    .hit_o  (rule_hit)
  );

  always_comb begin
    evt_d = valid_i & rule_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign evt_o = evt_q;

  logic [WORD_W-1:0] bit_mask;
  for (genvar g = 0; g < NUM_LANE; g++) begin : g_mask
    assign bit_mask[g*LANE_W +: LANE_W] = {LANE_W{sel_i[g]}};
  end

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !evt_o);
  p_rule_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_i == 2'b00) |=> !evt_o);
  p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '0) |=> !evt_o);
  p_all_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && rule_i == 2'b01 && sel_i != '0 &&
     ((data_i & bit_mask) == (ref_i & bit_mask))) |=> evt_o);
  p_any_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && rule_i == 2'b10 && (data_i & bit_mask) == '0 &&
     (ref_i & bit_mask) == '1 && sel_i != '0) |=> !evt_o);
endmodule

// File: rtl/dvm_value_match.sv
module dvm_value_match
  import dvm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [WORD_W-1:0] acc_data,
  input  logic [WORD_W-1:0] cmp_val_a,
  input  logic [3:0]        lane_sel_a,
  input  logic [1:0]        rule_a,
  input  logic [WORD_W-1:0] cmp_val_b,
  input  logic [3:0]        lane_sel_b,
  input  logic [1:0]        rule_b,
  output logic              evt_a,
  output logic              evt_b
);
  localparam int unsigned NUM_CH = 2;

  logic                       rst_sync_n;
  logic [NUM_CH-1:0][WORD_W-1:0]   ch_ref;
  logic [NUM_CH-1:0][NUM_LANE-1:0] ch_sel;
  logic [NUM_CH-1:0][1:0]          ch_rule;
  logic [NUM_CH-1:0]               ch_evt;

  dvm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ch_ref  = {cmp_val_b, cmp_val_a};
  assign ch_sel  = {lane_sel_b, lane_sel_a};
  assign ch_rule = {rule_b, rule_a};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dvm_channel #(.LANE_W(LANE_W), .NUM_LANE(NUM_LANE)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .valid_i (acc_valid),
      .data_i  (acc_data),
      .ref_i   (ch_ref[c]),
      .sel_i   (ch_sel[c]),
      .rule_i  (ch_rule[c]),
      .evt_o   (ch_evt[c])
    );
  end

  assign evt_a = ch_evt[0];
  assign evt_b = ch_evt[1];

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_sync_n |-> (!evt_a && !evt_b));
endmodule

// File: tb/dvm_value_match_tb.sv
module dvm_value_match_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] d;
    logic [31:0] va;
    logic [3:0]  sa;
    logic [1:0]  ma;
    logic [31:0] vb;
    logic [3:0]  sb;
    logic [1:0]  mb;
    logic        ea;
    logic        eb;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 32'hA1B2C3D4, 32'hA1B2C3D4, 4'hF, 2'b01, 32'hA1B2C3D5, 4'hF, 2'b01, 1'b1, 1'b0}, // R3
    '{4'd2, 32'hA1B2C3D4, 32'hFFB2C3D4, 4'h7, 2'b01, 32'hA1B2C3D4, 4'h8, 2'b01, 1'b1, 1'b1}, // R2
    '{4'd4, 32'hA1B2C3D4, 32'h00B20000, 4'hF, 2'b10, 32'h00B20000, 4'hB, 2'b10, 1'b1, 1'b0}, // R4
    '{4'd5, 32'hA1B2C3D4, 32'h0000C3D4, 4'hF, 2'b11, 32'h0000C3D4, 4'hD, 2'b11, 1'b1, 1'b0}, // R5
    '{4'd5, 32'hA1B2C3D4, 32'hA1B20000, 4'hC, 2'b11, 32'h00B2C300, 4'hF, 2'b11, 1'b1, 1'b0}, // R5
    '{4'd6, 32'hA1B2C3D4, 32'hA1B2C3D4, 4'hF, 2'b00, 32'hA1B2C3D4, 4'hF, 2'b10, 1'b0, 1'b1}, // R6
    '{4'd7, 32'hA1B2C3D4, 32'hA1B2C3D4, 4'h0, 2'b01, 32'hA1B2C3D4, 4'h0, 2'b10, 1'b0, 1'b0}, // R7
    '{4'd1, 32'hA1B2C3D4, 32'hA1B2C3D4, 4'hF, 2'b01, 32'h00000000, 4'hF, 2'b01, 1'b1, 1'b0}, // R1
    '{4'd2, 32'hA1B2C3D4, 32'h000000D4, 4'h1, 2'b10, 32'hD4000000, 4'h1, 2'b10, 1'b1, 1'b0}, // R2
    '{4'd7, 32'hA1B2C3D4, 32'hA1B2C3D4, 4'h0, 2'b11, 32'hA1B2C3D4, 4'hF, 2'b11, 1'b0, 1'b1}, // R7
    '{4'd1, 32'h00000000, 32'h00000000, 4'hF, 2'b01, 32'hFFFFFFFF, 4'hF, 2'b10, 1'b1, 1'b0}  // R1
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [31:0] acc_data, cmp_val_a, cmp_val_b;
  logic [3:0]  lane_sel_a, lane_sel_b;
  logic [1:0]  rule_a, rule_b;
  logic        evt_a, evt_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dvm_value_match dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_data(acc_data),
    .cmp_val_a(cmp_val_a), .lane_sel_a(lane_sel_a), .rule_a(rule_a),
    .cmp_val_b(cmp_val_b), .lane_sel_b(lane_sel_b), .rule_b(rule_b),
    .evt_a(evt_a), .evt_b(evt_b)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    acc_valid = vld; acc_data = v.d;
    cmp_val_a = v.va; lane_sel_a = v.sa; rule_a = v.ma;
    cmp_val_b = v.vb; lane_sel_b = v.sb; rule_b = v.mb;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t hit;
    hit = VECS[0];
    rst_n = 1'b0;
    drive(hit, 1'b1);
    repeat (3) @(negedge clk);
    check("R9", "evt_a in reset", evt_a, 1'b0);
    check("R9", "evt_b in reset", evt_b, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "evt_a before sync release", evt_a, 1'b0);
    acc_valid = 1'b0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      checks++;
      if (evt_a !== VECS[i].ea) begin
        errors++;
        $display("FAIL R%0d vec %0d evt_a: actual %b expected %b", VECS[i].req, i, evt_a, VECS[i].ea);
      end
      checks++;
      if (evt_b !== VECS[i].eb) begin
        errors++;
        $display("FAIL R%0d vec %0d evt_b: actual %b expected %b", VECS[i].req, i, evt_b, VECS[i].eb);
      end
      acc_valid = 1'b0;
      @(negedge clk);
    end

    drive(hit, 1'b0);
    @(negedge clk);
    check("R8", "no strobe evt_a", evt_a, 1'b0);
    check("R8", "no strobe evt_b", evt_b, 1'b0);

    acc_valid = 1'b1;
    @(negedge clk);
    check("R8", "pulse high", evt_a, 1'b1);
    acc_valid = 1'b0;
    @(negedge clk);
    check("R8", "pulse one cycle", evt_a, 1'b0);

    acc_valid = 1'b1;
    @(negedge clk);
    check("R8", "back-to-back first", evt_a, 1'b1);
    @(negedge clk);
    check("R8", "back-to-back second", evt_a, 1'b1);
    acc_valid = 1'b0;
    @(negedge clk);
    check("R8", "back-to-back end", evt_a, 1'b0);

    acc_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", "evt_a mid-run reset", evt_a, 1'b0);
    check("R9", "evt_b mid-run reset", evt_b, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule